// File: doc/BRIEF.md
# Audio Codec Link Frame Serializer

This block drives the outgoing half of a serial audio codec link. Once per sample period it sends one 256-bit frame on a single data line and raises a frame marker for the start of each frame. The `clk` input is the link bit clock (12.288 MHz for 48 kHz frames). Every output changes on its rising edge, so the codec can sample on the falling edge.

A frame starts with a 16-bit tag word. Twelve 20-bit slots follow it. Only the first four slots carry data: command address, command data, left PCM sample and right PCM sample. The host hands over one frame as parallel words through a valid/ready handshake into a single holding register. The block copies that register into its shift state at each frame boundary and keeps the copy unchanged while the frame goes out. Slots 5 to 12, slots not flagged in the tag, and every slot of a frame whose tag marks it invalid are sent as zeros. If no frame is waiting at a boundary, the block sends an all-zero frame.

Top module: `acl_frame_tx`

## Requirements
- R1: A frame lasts exactly 256 bit clocks. `frame_done` is high for one clock, during the last bit position of each frame, and the marker of the next frame rises on the following clock.
- R2: `sync` is high for 16 consecutive bit clocks at the start of each frame and low for the other 240.
- R3: Data leaves MSB first. In the first clock that `sync` is high, the line carries the last bit of the previous frame, which is always 0. Tag bit 15 follows on the next clock, and tag bits 14..0 follow in order.
- R4: Slots 1..4 come after the tag, 20 bits each, MSB first. Slot k uses input `in_slot<k>`. Slot k is sent as given when tag bit 15 and tag bit (15-k) are both 1. The flags are bit 14 for slot 1, bit 13 for slot 2, bit 12 for slot 3 and bit 11 for slot 4.
- R5: Slots 5..12 are always sent as zeros, whatever tag bits 10..3 hold.
- R6: A slot among 1..4 whose flag bit is 0 is sent as zeros. If tag bit 15 is 0, all slots are sent as zeros. The tag itself is always sent exactly as supplied.
- R7: `in_ready` is high while the holding register is empty. A frame is accepted on a clock edge where `in_valid` and `in_ready` are both high, and it is sent as the next frame to start after acceptance. `in_valid` while `in_ready` is low is ignored. A frame already being sent is not changed by new input.
- R8: If no frame has been accepted before a frame boundary, that frame is sent with tag and all slots zero.
- R9: While `rst_n` is low (synchronous, active low), `sync`, `sdata` and `frame_done` are low, any pending frame is dropped, and the bit position returns to 0. `sync` rises on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock; all outputs change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host offers a frame |
| in_ready | output | 1 | Holding register is empty and can take a frame |
| in_tag | input | 16 | Tag word: bit 15 marks the frame valid, bits 14..11 flag slots 1..4 |
| in_slot1 | input | 20 | Command address slot payload |
| in_slot2 | input | 20 | Command data slot payload |
| in_slot3 | input | 20 | Left PCM slot payload |
| in_slot4 | input | 20 | Right PCM slot payload |
| sync | output | 1 | Frame marker, high during the 16 tag bit times |
| sdata | output | 1 | Serial data, MSB first |
| frame_done | output | 1 | One-clock strobe at the last bit position of a frame |

## Verification
The hardest case to reach from the ports is a new frame arriving while another is halfway out on the line. This is the only case that tests whether the frame in flight stays fixed and whether a second offer is refused while the holding register is full. The bench gets there by offering one frame and waiting for it to start. About a hundred bits into that frame it offers a second frame, which is accepted. Fifty bits later it offers a third frame while `in_ready` is low. It then checks the frame in flight, the frame after it, and that the third frame never appears. A reset in the middle of a frame, with a frame still pending, shows that the pending frame is dropped.

// File: rtl/acl_pkg.sv
// Shared sizes and the parallel frame type for the codec link serializer.
// Assumes one tag word followed by a fixed number of equal-width slots.
package acl_pkg;
    localparam int unsigned TAG_W      = 16;
    localparam int unsigned SLOT_W     = 20;
    localparam int unsigned NSLOT      = 12;
    localparam int unsigned NDATA      = 4;
    localparam int unsigned FRAME_LEN  = TAG_W + NSLOT * SLOT_W;
    localparam int unsigned CNT_W      = $clog2(FRAME_LEN);
    localparam int unsigned SLOT_IDX_W = $clog2(NSLOT + 1);
    localparam int unsigned SBIT_W     = $clog2(SLOT_W);

    // slot[0] is the first slot after the tag
    typedef struct packed {
        logic [TAG_W-1:0]             tag;
        logic [NDATA-1:0][SLOT_W-1:0] slot;
    } frame_t;
endpackage

// File: rtl/acl_bit_timer.sv
// Bit position counter with slot index and bit-in-slot tracking.
// slot_idx is 0 during the tag phase (and position 0), 1..NSLOT afterwards.
// Assumes FRAME_LEN positions per frame; wraps free-running.
module acl_bit_timer
    import acl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [CNT_W-1:0]      cnt,
    output logic [SLOT_IDX_W-1:0] slot_idx,
    output logic [SBIT_W-1:0]     slot_bit
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] TAG_END  = CNT_W'(TAG_W);

    // Advance the bit position and wrap at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (cnt == LAST_POS) cnt <= '0;
        else                      cnt <= cnt + 1'b1;
    end

    // Track which slot and which bit of it the next position belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_idx <= '0;
            slot_bit <= SBIT_W'(SLOT_W - 1);
        end else if (cnt == LAST_POS) begin
            slot_idx <= '0;
            slot_bit <= SBIT_W'(SLOT_W - 1);
        end else if (cnt == TAG_END) begin
            slot_idx <= SLOT_IDX_W'(1);
            slot_bit <= SBIT_W'(SLOT_W - 1);
        end else if (slot_idx != '0) begin
            if (slot_bit == '0) begin
                slot_idx <= slot_idx + 1'b1;
                slot_bit <= SBIT_W'(SLOT_W - 1);
            end else begin
                slot_bit <= slot_bit - 1'b1;
            end
        end
    end

    AST_SLOT_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_bit < SBIT_W'(SLOT_W)); // R4
    AST_TAG_PHASE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == '0 && cnt != '0) |-> cnt <= TAG_END); // R2
    AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= SLOT_IDX_W'(NSLOT)); // R5
endmodule

// File: rtl/acl_frame_hold.sv
// One-deep holding register with valid/ready intake, plus the frame copy
// that is shifted out. At each boundary (load) the held frame, with invalid
// slots zeroed, becomes current; with nothing held, an all-zero frame does.
module acl_frame_hold
    import acl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   in_valid,
    output logic   in_ready,
    input  frame_t in_frm,
    input  logic   load,
    output frame_t cur
);
    frame_t nxt;
    frame_t nxt_msk;
    logic   nxt_vld;

    assign in_ready = !nxt_vld;

    // Mask each data slot with the frame-valid bit and its own flag.
    assign nxt_msk.tag = nxt.tag;
    for (genvar k = 0; k < NDATA; k++) begin : g_mask
        assign nxt_msk.slot[k] = (nxt.tag[TAG_W-1] && nxt.tag[TAG_W-2-k])
                               ? nxt.slot[k] : '0;
    end

    // Accept a frame when empty; empty the register at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt     <= '0;
            nxt_vld <= 1'b0;
        end else if (in_valid && in_ready) begin
            nxt     <= in_frm;
            nxt_vld <= 1'b1;
        end else if (load) begin
            nxt_vld <= 1'b0;
        end
    end

    // Copy the held (or an empty) frame into the shift state at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur <= '0;
        else if (load) cur <= nxt_vld ? nxt_msk : '0;
    end

    AST_CUR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cur)); // R7
    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_vld && !load) |=> (nxt_vld && $stable(nxt))); // R7
endmodule

// File: rtl/acl_bit_select.sv
// Picks the frame bit for the current position: tag bits MSB first during
// positions 1..TAG_W, data slot bits MSB first afterwards, zero elsewhere.
// Purely combinational; assumes cur is already masked.
module acl_bit_select
    import acl_pkg::*;
(
    input  logic [CNT_W-1:0]      cnt,
    input  logic [SLOT_IDX_W-1:0] slot_idx,
    input  logic [SBIT_W-1:0]     slot_bit,
    input  frame_t                cur,
    output logic                  bit_o
);
    // Decode the position into one bit of the current frame.
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < TAG_W; i++) begin
            if (cnt == CNT_W'(TAG_W - i)) bit_o = cur.tag[i];
        end
        for (int k = 0; k < NDATA; k++) begin
            for (int b = 0; b < SLOT_W; b++) begin
                if (slot_idx == SLOT_IDX_W'(k + 1) && slot_bit == SBIT_W'(b))
                    bit_o = cur.slot[k][b];
            end
        end
    end
endmodule

// File: rtl/acl_frame_tx.sv
// Codec link frame serializer top. Sends one FRAME_LEN-bit frame per period
// on sdata, MSB first, with sync high for the tag phase. Outputs are
// registered on the rising bit-clock edge. Assumes clk is the link bit clock.
module acl_frame_tx
    import acl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [SLOT_W-1:0] in_slot1,
    input  logic [SLOT_W-1:0] in_slot2,
    input  logic [SLOT_W-1:0] in_slot3,
    input  logic [SLOT_W-1:0] in_slot4,
    output logic              sync,
    output logic              sdata,
    output logic              frame_done
);
    logic [CNT_W-1:0]      cnt;
    logic [SLOT_IDX_W-1:0] slot_idx;
    logic [SBIT_W-1:0]     slot_bit;
    frame_t                in_frm;
    frame_t                cur;
    logic                  load;
    logic                  next_bit;

    assign in_frm = {in_tag, in_slot4, in_slot3, in_slot2, in_slot1};
    assign load   = (cnt == '0);

    acl_bit_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .slot_idx (slot_idx),
        .slot_bit (slot_bit)
    );

    acl_frame_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_frm   (in_frm),
        .load     (load),
        .cur      (cur)
    );

    acl_bit_select u_sel (
        .cnt      (cnt),
        .slot_idx (slot_idx),
        .slot_bit (slot_bit),
        .cur      (cur),
        .bit_o    (next_bit)
    );

    // Register the line outputs so they change only on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync       <= 1'b0;
            sdata      <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            sync       <= (cnt < CNT_W'(TAG_W));
            sdata      <= next_bit;
            frame_done <= (cnt == CNT_W'(FRAME_LEN - 1));
        end
    end

    AST_SYNC_FALL_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync) |-> cnt == CNT_W'(TAG_W + 1)); // R2
    AST_DONE_THEN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> $rose(sync)); // R1
    AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx > SLOT_IDX_W'(NDATA)) |=> !sdata); // R5
    AST_INVALID_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur.tag[TAG_W-1] && slot_idx != '0) |=> !sdata); // R6
endmodule

// File: tb/acl_frame_tx_bench.sv
module acl_frame_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_tag;
    logic [19:0] in_slot1, in_slot2, in_slot3, in_slot4;
    logic        sync, sdata, frame_done;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    acl_frame_tx u_acl_frame_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_slot1(in_slot1), .in_slot2(in_slot2),
        .in_slot3(in_slot3), .in_slot4(in_slot4),
        .sync(sync), .sdata(sdata), .frame_done(frame_done)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected value of frame bit j (0 = tag bit 15)
    function automatic logic exp_bit(input int j, input logic [15:0] tag,
                                     input logic [3:0][19:0] sl);
        int s, b;
        if (j < 16) return tag[15-j];
        s = (j - 16) / 20 + 1;
        b = 19 - (j - 16) % 20;
        if (s > 4 || !tag[15] || !tag[15-s]) return 1'b0;
        return sl[s-1][b];
    endfunction

    task automatic offer(input logic [15:0] tag, input logic [3:0][19:0] sl);
        in_tag = tag; in_slot1 = sl[0]; in_slot2 = sl[1];
        in_slot3 = sl[2]; in_slot4 = sl[3];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!frame_done);
    endtask

    // Sample one full frame starting at the next negedge and compare it.
    task automatic grab(input logic [15:0] tag, input logic [3:0][19:0] sl,
                        input string tagname);
        int bad_s = 0, bad_d = 0, bad_f = 0, first_d = -1;
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            if (sync !== (k < 16)) bad_s++;
            if (frame_done !== (k == 255)) bad_f++;
            if (sdata !== ((k == 0) ? 1'b0 : exp_bit(k - 1, tag, sl))) begin
                bad_d++;
                if (first_d < 0) first_d = k;
            end
        end
        chk(bad_s == 0, "R2", {tagname, " sync mismatches"}, bad_s, 0);
        chk(bad_f == 0, "R1", {tagname, " frame_done mismatches"}, bad_f, 0);
        chk(bad_d == 0, "R3/R4/R5/R6", {tagname, " data mismatches (first pos below is count)"}, bad_d, 0);
    endtask

    localparam logic [3:0][19:0] ZS = '0;

    task automatic run_vec(input logic [15:0] tag, input logic [3:0][19:0] sl,
                           input string nm);
        offer(tag, sl);
        chk(in_ready == 1'b0, "R7", {nm, " ready after accept"}, int'(in_ready), 0);
        wait_done();
        grab(tag, sl, nm);
        grab(16'h0, ZS, {nm, " then empty R8"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [3:0][19:0] sl;
        logic [3:0][19:0] sw;
        logic [3:0][19:0] sx;
        rst_n = 1'b0; in_valid = 1'b0;
        in_tag = '0; in_slot1 = '0; in_slot2 = '0; in_slot3 = '0; in_slot4 = '0;
        repeat (3) @(negedge clk);
        chk(sync == 1'b0, "R9", "sync in reset", int'(sync), 0);
        chk(sdata == 1'b0, "R9", "sdata in reset", int'(sdata), 0);
        chk(frame_done == 1'b0, "R9", "frame_done in reset", int'(frame_done), 0);
        chk(in_ready == 1'b1, "R9", "ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sync == 1'b1, "R9", "sync on first edge after reset", int'(sync), 1);
        wait_done();
        grab(16'h0, ZS, "idle R8");

        // Sweep all slot flag combinations with the frame marked valid
        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < 4; k++)
                sl[k] = 20'(32'h9A3C5 * (m + 1) + k * 32'h1F0F1);
            run_vec({1'b1, 4'(m), 11'(m * 157)}, sl, $sformatf("sweep m=%0d R4", m));
        end
        for (int k = 0; k < 4; k++) sl[k] = 20'hFFFFF - 20'(k * 3);
        run_vec(16'hE000, sl, "cmd tag R4");
        run_vec(16'hFFF8, sl, "all flags R5");
        run_vec(16'h7800, sl, "frame invalid R6");
        run_vec(16'h9000, sl, "slot3 only R6");
        run_vec(16'h0000, sl, "zero tag R6");

        // Offers while a frame is in flight (R7)
        for (int k = 0; k < 4; k++) begin
            sl[k] = 20'hA5A5A ^ 20'(k);
            sw[k] = 20'h3C3C3 + 20'(k * 7);
            sx[k] = 20'hFFFFF;
        end
        offer(16'hF800, sl);
        wait_done();
        fork
            grab(16'hF800, sl, "in flight R7");
            begin
                repeat (100) @(negedge clk);
                offer(16'hD000, sw);
                chk(in_ready == 1'b0, "R7", "ready with held frame", int'(in_ready), 0);
                repeat (50) @(negedge clk);
                offer(16'hF800, sx);
                chk(in_ready == 1'b0, "R7", "ready still low", int'(in_ready), 0);
            end
        join
        grab(16'hD000, sw, "held frame R7");
        grab(16'h0, ZS, "refused offer R7");

        // Reset in mid-frame with a frame pending (R9)
        offer(16'hF800, sl);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sync == 1'b0, "R9", "sync mid reset", int'(sync), 0);
        chk(sdata == 1'b0, "R9", "sdata mid reset", int'(sdata), 0);
        chk(in_ready == 1'b1, "R9", "pending dropped", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sync == 1'b1, "R9", "sync restart", int'(sync), 1);
        wait_done();
        grab(16'h0, ZS, "after reset R9");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule